// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

The block is a watchdog timer that counts cycles of the system enable clock. It raises a one-cycle reset request when software stops servicing it. Software services the timer through a register bus with two addresses. The control register at address 0 sets the timeout rate, a disable-reset bit and a force-reset bit. The service register at address 1 must receive the key 0x55 and then the key 0xAA before the selected timeout elapses. A mode input sets the write rules. In normal mode the rate can be written once and the other control bits are locked. In special mode every bit can be written at any time. In special mode a test-bypass input also drops two prescaler stages.

The bus has no flow control. A write takes effect at the clock edge where `bus_wr` is high, and read data is a combinational function of `bus_addr`. The timeout exponents are 13, 15, 17, 19, 21, 22 and 23. The parameter `EXP_TRIM` lowers every exponent by the same amount so that shortened instances can be built for simulation. With the default of 0 the periods are the full ones.

Top module: `kwd_watchdog`

## Requirements
- R1: After reset the control register reads 0x00 (rate code 0, disable-reset clear) and `wdt_rst_req` is low.
- R2: Rate code 0 (control bits 2:0) stops the watchdog, and no request is raised for any cause. Codes 1..7 give a timeout of 2^(E-EXP_TRIM) cycles, with E being 13, 15, 17, 19, 21, 22 and 23 respectively. Left unserviced, the block pulses exactly once per period.
- R3: With `mode_special` and `test_bypass` both high, each period is four times shorter. In normal mode `test_bypass` has no effect.
- R4: Writing 0x55 to address 1 arms the key. A later 0xAA to address 1 restarts the count, so the next request comes one full period after that write. Other bus writes may fall between the two keys, and a repeated 0x55 keeps the key armed.
- R5: A 0xAA written while the key is not armed is ignored and does not restart the count.
- R6: Writing to address 1 any value other than 0x55 or 0xAA, while the watchdog is enabled and reset is not disabled, raises the request at the next clock edge.
- R7: Address 1 always reads 0x00. Address 0 reads the disable-reset bit in bit 6 and the rate in bits 2:0. All other bits read 0, and the force bit (bit 7) is write-only.
- R8: Writing the force bit (bit 7 of address 0) in special mode raises a request at the next edge when the rate is not 0. With rate 0 it does nothing. The rate and disable settings in effect before that write decide this.
- R9: While the disable-reset bit (bit 6) is set, no request is raised by timeout, bad key or force.
- R10: In normal mode the first write to address 0 loads only the rate, and later writes change nothing. Force and disable-reset cannot be written in normal mode. In special mode all control bits are writable at any time.
- R11: The request lasts one cycle. When it fires, the count returns to zero and any armed key is dropped.
- R12: A write that changes the rate code restarts the count, so the next request comes one new period after that write.
- R13: A 0xAA that completes the key in the very cycle the count expires is too late: the request still fires, and the count restarts from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System enable clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_special | input | 1 | 1 = special mode (free control writes, bypass allowed) |
| test_bypass | input | 1 | Skip two prescaler stages (special mode only) |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 1 | 0 = control register, 1 = service register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The closing 0xAA key and the expiry of the count can land in the same cycle. The bench provokes this after a pulse by writing 0x55 and then idling so that the 0xAA edge coincides with the expiry edge. It judges the result by seeing the request at that edge and the next pulse one full period later. It runs the same key one cycle earlier as a contrast, where no pulse may appear and the next pulse must come a full period after the key.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  // prescaler stages dropped by the test bypass
  localparam int BYPASS_STAGES = 2;

  // largest exponent of the rate table
  localparam int TOP_EXP = 23;

  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_ARMED = 1'b1
  } key_state_e;

  // timeout exponent for a rate code; 0 means stopped
  function automatic int rate_exp(input logic [2:0] code);
    case (code)
      3'd1:    return 13;
      3'd2:    return 15;
      3'd3:    return 17;
      3'd4:    return 19;
      3'd5:    return 21;
      3'd6:    return 22;
      3'd7:    return 23;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/kwd_ctrlreg.sv
module kwd_ctrlreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special,
  input  logic       wr,
  input  logic       wd_force,
  input  logic       wd_dis,
  input  logic [2:0] wd_rate,
  output logic [2:0] rate,
  output logic       dis,
  output logic       locked,
  output logic       force_hit,
  output logic       rate_load
);

  logic [2:0] rate_q;
  logic       dis_q;
  logic       lock_q;
  logic       rate_we;
  logic       dis_we;

  // normal mode: rate only, and only before the first write
  assign rate_we   = wr && (special || !lock_q);
  assign dis_we    = wr && special;
  assign force_hit = wr && special && wd_force;
  assign rate_load = rate_we && (wd_rate != rate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      dis_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (rate_we) rate_q <= wd_rate;
      if (dis_we)  dis_q  <= wd_dis;
      if (wr && !special) lock_q <= 1'b1;
    end
  end

  assign rate   = rate_q;
  assign dis    = dis_q;
  assign locked = lock_q;

endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_wr,
  input  logic [7:0] wdata,
  input  logic       flush,
  output logic       service,
  output logic       bad_key,
  output logic       armed
);

  key_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    service = 1'b0;
    bad_key = 1'b0;
    if (svc_wr) begin
      if (wdata == KEY_ARM) begin
        st_d = KS_ARMED;
      end else if (wdata == KEY_FIRE) begin
        if (st_q == KS_ARMED) begin
          service = 1'b1;
          st_d    = KS_IDLE;
        end
      end else begin
        bad_key = 1'b1;
        st_d    = KS_IDLE;
      end
    end
    if (flush) st_d = KS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == KS_ARMED);

endmodule

// File: rtl/kwd_timebase.sv
module kwd_timebase
  import kwd_pkg::*;
#(
  parameter int EXP_TRIM = 0,
  localparam int CNT_W   = TOP_EXP - EXP_TRIM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rate,
  input  logic             byp,
  input  logic             clr,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       hit_n;
  logic [7:0]       hit_b;

  assign hit_n[0] = 1'b0;
  assign hit_b[0] = 1'b0;

  // one terminal comparator per rate code, normal and bypassed
  for (genvar c = 1; c < 8; c++) begin : g_term
    localparam int EN = rate_exp(3'(c)) - EXP_TRIM;
    localparam int EB = EN - BYPASS_STAGES;
    localparam logic [63:0] TN64 = (64'd1 << EN) - 64'd1;
    localparam logic [63:0] TB64 = (64'd1 << EB) - 64'd1;
    localparam logic [CNT_W-1:0] TN = TN64[CNT_W-1:0];
    localparam logic [CNT_W-1:0] TB = TB64[CNT_W-1:0];
    assign hit_n[c] = (cnt_q == TN);
    assign hit_b[c] = (cnt_q == TB);
  end

  assign expire = byp ? hit_b[rate] : hit_n[rate];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (rate != 3'd0)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog
  import kwd_pkg::*;
#(
  parameter int EXP_TRIM = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_special,
  input  logic       test_bypass,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdt_rst_req
);

  localparam int CNT_W = TOP_EXP - EXP_TRIM;

  logic [2:0]       rate_w;
  logic             dis_w;
  logic             locked_w;
  logic             force_hit;
  logic             rate_load;
  logic             service;
  logic             bad_key;
  logic             armed_w;
  logic             expire;
  logic [CNT_W-1:0] cnt_w;
  logic             req_c;
  logic             req_q;
  logic             cnt_clr;

  kwd_ctrlreg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .special   (mode_special),
    .wr        (bus_wr && !bus_addr),
    .wd_force  (bus_wdata[7]),
    .wd_dis    (bus_wdata[6]),
    .wd_rate   (bus_wdata[2:0]),
    .rate      (rate_w),
    .dis       (dis_w),
    .locked    (locked_w),
    .force_hit (force_hit),
    .rate_load (rate_load)
  );

  kwd_keyseq u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .svc_wr  (bus_wr && bus_addr),
    .wdata   (bus_wdata),
    .flush   (req_c),
    .service (service),
    .bad_key (bad_key),
    .armed   (armed_w)
  );

  kwd_timebase #(.EXP_TRIM(EXP_TRIM)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .rate   (rate_w),
    .byp    (mode_special && test_bypass),
    .clr    (cnt_clr),
    .expire (expire),
    .cnt    (cnt_w)
  );

  // a request needs a running rate, no disable, and no pulse in flight
  assign req_c   = (rate_w != 3'd0) && !dis_w && !req_q &&
                   (expire || bad_key || force_hit);
  assign cnt_clr = req_c || expire || service || rate_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_c;
  end

  assign wdt_rst_req = req_q;
  assign bus_rdata   = bus_addr ? 8'h00 : {1'b0, dis_w, 3'b000, rate_w};

endmodule

// File: rtl/kwd_watchdog_chk.sv
module kwd_watchdog_chk #(
  parameter int CNT_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             special,
  input logic             bus_wr,
  input logic             bus_addr,
  input logic [7:0]       rdata,
  input logic [2:0]       rate,
  input logic             dis,
  input logic             locked,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             req
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req); // R11

  AST_REQ_CLEARS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (cnt == '0) && !armed); // R11

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 3'd0) |=> !req); // R2

  AST_DIS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> !req); // R9

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!special && locked && bus_wr && !bus_addr) |=> $stable(rate)); // R10

  AST_NORMAL_DIS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!special && bus_wr && !bus_addr) |=> $stable(dis)); // R10

  AST_SVC_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr |-> (rdata == 8'h00)); // R7

endmodule

bind kwd_watchdog kwd_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .special  (mode_special),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .rdata    (bus_rdata),
  .rate     (rate_w),
  .dis      (dis_w),
  .locked   (locked_w),
  .armed    (armed_w),
  .cnt      (cnt_w),
  .req      (wdt_rst_req)
);

// File: tb/kwd_watchdog_bench.sv
`timescale 1ns/1ps
module kwd_watchdog_bench;

  localparam int TRIM = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_special = 1'b0;
  logic       test_bypass = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  wire  [7:0] bus_rdata;
  wire        wdt_rst_req;

  int checks = 0;
  int fails = 0;
  int pcnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kwd_watchdog #(.EXP_TRIM(TRIM)) u_kwd_watchdog (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_special (mode_special),
    .test_bypass  (test_bypass),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .wdt_rst_req  (wdt_rst_req)
  );

  always @(negedge clk) if (rst_n && wdt_rst_req) pcnt++;

  typedef struct packed {
    logic        sp;
    logic        bp;
    logic [2:0]  rate;
    logic [31:0] per;
  } vec_t;

  // period in cycles with EXP_TRIM = 8
  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b0, 3'd1, 32'd32},
    '{1'b1, 1'b0, 3'd2, 32'd128},
    '{1'b1, 1'b0, 3'd3, 32'd512},
    '{1'b1, 1'b0, 3'd4, 32'd2048},
    '{1'b1, 1'b0, 3'd5, 32'd8192},
    '{1'b1, 1'b0, 3'd6, 32'd16384},
    '{1'b1, 1'b1, 3'd1, 32'd8},
    '{1'b1, 1'b1, 3'd7, 32'd8192},
    '{1'b0, 1'b1, 3'd1, 32'd32},
    '{1'b0, 1'b0, 3'd2, 32'd128}
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit sp);
    rst_n = 1'b0; mode_special = sp; test_bypass = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic next_pulse(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wdt_rst_req && n < limit);
  endtask

  initial begin
    int n;
    int p0;
    idle(2);

    // R1 reset state
    do_reset(1'b0);
    check(bus_rdata == 8'h00, "R1 ctrl after reset", bus_rdata, 0);
    check(wdt_rst_req == 1'b0, "R1 req after reset", wdt_rst_req, 0);

    // R2 / R3 period table
    foreach (VECS[i]) begin
      do_reset(VECS[i].sp);
      test_bypass = VECS[i].bp;
      wr(1'b0, {5'b0, VECS[i].rate});
      next_pulse(2 * int'(VECS[i].per) + 10, n);
      next_pulse(2 * int'(VECS[i].per) + 10, n);
      check(n == int'(VECS[i].per), VECS[i].bp ? "R3 bypass period" : "R2 period",
            n, int'(VECS[i].per));
    end

    // R10 normal-mode write rules
    do_reset(1'b0);
    wr(1'b0, 8'h41);
    check(bus_rdata == 8'h01, "R10 first write rate only", bus_rdata, 8'h01);
    wr(1'b0, 8'h03);
    check(bus_rdata == 8'h01, "R10 rate locked", bus_rdata, 8'h01);
    wr(1'b0, 8'h81);
    check(wdt_rst_req == 1'b0, "R10 force ignored in normal", wdt_rst_req, 0);

    // R4 servicing with bus traffic between keys
    p0 = pcnt;
    for (int k = 0; k < 6; k++) begin
      wr(1'b1, 8'h55);
      wr(1'b0, 8'h02);
      idle(10);
      wr(1'b1, 8'hAA);
      idle(5);
    end
    check(pcnt == p0, "R4 serviced no pulse", pcnt - p0, 0);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
    next_pulse(100, n);
    check(n == 32, "R4 repeated arm then service", n, 32);

    // R5 lone 0xAA ignored
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
    idle(10);
    wr(1'b1, 8'hAA);
    next_pulse(100, n);
    check(n == 21, "R5 lone key ignored", n, 21);

    // R6 bad key, R11 pulse width and clearing
    idle(5);
    wr(1'b1, 8'h12);
    check(wdt_rst_req == 1'b1, "R6 bad key request", wdt_rst_req, 1);
    @(negedge clk);
    check(wdt_rst_req == 1'b0, "R11 single cycle", wdt_rst_req, 0);
    next_pulse(100, n);
    check(n == 31, "R11 count cleared by request", n, 31);
    wr(1'b1, 8'h55);
    next_pulse(100, n);
    check(n == 31, "R11 sync pulse", n, 31);
    wr(1'b1, 8'hAA);
    next_pulse(100, n);
    check(n == 31, "R11 arming dropped by request", n, 31);

    // R7 service register reads zero
    wr(1'b1, 8'h55);
    bus_addr = 1'b1;
    #0.5;
    check(bus_rdata == 8'h00, "R7 service reads zero", bus_rdata, 0);
    bus_addr = 1'b0;

    // R13 key completing on the expiry cycle
    next_pulse(100, n);
    wr(1'b1, 8'h55);
    idle(30);
    wr(1'b1, 8'hAA);
    check(wdt_rst_req == 1'b1, "R13 expiry wins", wdt_rst_req, 1);
    next_pulse(100, n);
    check(n == 32, "R13 restart after collision", n, 32);
    wr(1'b1, 8'h55);
    idle(29);
    wr(1'b1, 8'hAA);
    check(wdt_rst_req == 1'b0, "R13 one cycle earlier serviced", wdt_rst_req, 0);
    next_pulse(100, n);
    check(n == 32, "R13 early key restarts", n, 32);

    // R12 rate change restarts count
    do_reset(1'b1);
    wr(1'b0, 8'h01);
    next_pulse(100, n);
    idle(10);
    wr(1'b0, 8'h02);
    next_pulse(300, n);
    check(n == 128, "R12 rate change restart", n, 128);

    // R8 force
    wr(1'b0, 8'h01);
    idle(3);
    wr(1'b0, 8'h81);
    check(wdt_rst_req == 1'b1, "R8 force request", wdt_rst_req, 1);
    check(bus_rdata == 8'h01, "R7 force bit reads zero", bus_rdata, 8'h01);
    wr(1'b0, 8'h00);
    p0 = pcnt;
    wr(1'b0, 8'h80);
    idle(2);
    check(pcnt == p0, "R8 force with rate off", pcnt - p0, 0);

    // R2 stopped watchdog ignores everything
    wr(1'b1, 8'h12);
    idle(300);
    check(pcnt == p0, "R2 rate off silent", pcnt - p0, 0);

    // R9 disable
    wr(1'b0, 8'h41);
    check(bus_rdata == 8'h41, "R9 disable readback", bus_rdata, 8'h41);
    p0 = pcnt;
    idle(100);
    wr(1'b1, 8'h12);
    wr(1'b0, 8'hC1);
    idle(5);
    check(pcnt == p0, "R9 disabled silent", pcnt - p0, 0);
    wr(1'b0, 8'h01);
    next_pulse(100, n);
    check(n >= 1 && n <= 32, "R9 re-enabled pulses", n, 32);

    // R1 reset mid-run
    do_reset(1'b0);
    check(bus_rdata == 8'h00 && wdt_rst_req == 1'b0, "R1 reset mid-run", bus_rdata, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule